// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Noise and Overrun Flags

This block receives asynchronous serial characters on a single line. A qualifying enable, pulsed at sixteen times the bit rate, paces a phase counter through each bit. The block takes seven samples around the centre of the start bit and three samples around the centre of every data bit and the stop bit. Each bit resolves to the majority of its samples, and any split vote marks the character as noisy.

A finished character moves from the shift register into a one-deep holding register and raises a full flag. If the holding register is still occupied when the next character finishes, the new character and its noise information are dropped and an overrun flag is raised instead. Software clears the flags with a two-step handshake: a status read that sees the full flag set, then a data read. Frames carry 8 or 9 data bits, least significant bit first, and a mode input chooses the width.

Top module: `uart_ovs_rx`

## Requirements
- R1: `rx_full` rises on the clock edge that follows the sample-tick edge at phase 15 of the stop bit, which is the edge where a character is transferred into the holding register.
- R2: `rx_full` clears only on a `data_rd` pulse that comes after a `stat_rd` pulse issued while `rx_full` was 1. A `data_rd` pulse with no such prior status read leaves every flag and `rx_data` unchanged.
- R3: Data bits arrive least significant bit first. With `nine_bit`=0, `rx_data[7:0]` holds the 8 data bits and `rx_data[8]` is 0. With `nine_bit`=1, `rx_data[8:0]` holds all 9 data bits.
- R4: If a character finishes while `rx_full` is 1 and is not being cleared in that cycle, `rx_ovr` is set. `rx_data` and `rx_noise` keep the earlier character's values.
- R5: The status-then-data handshake that clears `rx_full` also clears `rx_ovr` and `rx_noise`.
- R6: `rx_noise` is set in the same cycle as `rx_full` whenever any bit of that character, including the start and stop bits, had samples that did not all agree.
- R7: Each bit takes the majority value of its samples, so a single wrong sample inside a data bit does not change the received data.
- R8: A start bit whose seven samples have a majority of 1 is a false start. No character is produced, and the receiver goes back to looking for a low level on the line.
- R9: Phases are counted from the tick at which a low level is first seen (phase 0). The start bit is sampled at phases 5 to 11, and the data bits and stop bit at phases 7 to 9. Line values at any other phase affect neither the data nor `rx_noise`.
- R10: While `rst` is high, and on the cycle after it, `rx_full`, `rx_ovr`, `rx_noise` and `rx_data` are all 0.
- R11: Reception advances only on cycles where `tick` is 1. With `tick` held low, line activity produces no character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample enable at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| stat_rd | input | 1 | Status read strobe; arms the flag clear when `rx_full` is 1 |
| data_rd | input | 1 | Data read strobe; completes an armed clear |
| rx_data | output | 9 | Holding register contents |
| rx_full | output | 1 | Holding register has an unread character |
| rx_ovr | output | 1 | A character was lost to overrun |
| rx_noise | output | 1 | The held character had a split sample vote |

## Verification
A character becomes visible exactly one clock after the tick at phase 15 of its stop bit, with data, full and noise all updating together. The flag clear takes effect one clock after the `data_rd` pulse. The bench steps a behavioural model on the same edge as the design and compares every output a quarter period after each edge, so a result that shows up one cycle early or late is caught. The named checks are read only after the model and the design have both settled: idle ticks follow each frame and each strobe before the check.

// File: rtl/uart_ovs_pkg.sv
package uart_ovs_pkg;

    localparam int DATA_MAX_W = 9;
    localparam int VOTE_W     = 3;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic                  valid;
        logic                  noisy;
        logic [DATA_MAX_W-1:0] word;
    } rx_char_t;

    // Strict majority of the samples taken.
    function automatic logic vote_major(logic [VOTE_W-1:0] ones, logic [VOTE_W-1:0] taken);
        return {ones, 1'b0} > {1'b0, taken};
    endfunction

    // Samples of one bit disagree.
    function automatic logic vote_split(logic [VOTE_W-1:0] ones, logic [VOTE_W-1:0] taken);
        return (ones != '0) && (ones != taken);
    endfunction

endpackage

// File: rtl/uart_ovs_voter.sv
module uart_ovs_voter
    import uart_ovs_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int CNT_W = $clog2(OVS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             rxd,
    input  logic [CNT_W-1:0] phase,
    input  logic             wide,
    input  logic             bit_end,
    output logic             bit_val,
    output logic             bit_noisy
);
    localparam int MID = OVS / 2;
    localparam logic [CNT_W-1:0] WIDE_LO   = CNT_W'(MID - 3);
    localparam logic [CNT_W-1:0] WIDE_HI   = CNT_W'(MID + 3);
    localparam logic [CNT_W-1:0] NARROW_LO = CNT_W'(MID - 1);
    localparam logic [CNT_W-1:0] NARROW_HI = CNT_W'(MID + 1);

    logic [VOTE_W-1:0] ones_q;
    logic [VOTE_W-1:0] taken_q;
    logic              in_win;

    always_comb begin
        if (wide)
            in_win = (phase >= WIDE_LO) && (phase <= WIDE_HI);
        else
            in_win = (phase >= NARROW_LO) && (phase <= NARROW_HI);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ones_q  <= '0;
            taken_q <= '0;
        end else if (tick) begin
            if (bit_end) begin
                ones_q  <= '0;
                taken_q <= '0;
            end else if (in_win) begin
                ones_q  <= ones_q + VOTE_W'(rxd);
                taken_q <= taken_q + 1'b1;
            end
        end
    end

    assign bit_val   = vote_major(ones_q, taken_q);
    assign bit_noisy = vote_split(ones_q, taken_q);

endmodule

// File: rtl/uart_ovs_frame.sv
module uart_ovs_frame
    import uart_ovs_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int CNT_W = $clog2(OVS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             rxd,
    input  logic             nine_bit,
    input  logic             bit_val,
    input  logic             bit_noisy,
    output logic [CNT_W-1:0] phase,
    output logic             wide,
    output logic             bit_end,
    output rx_char_t         char_out
);
    localparam logic [CNT_W-1:0] PH_LAST = CNT_W'(OVS - 1);
    localparam int IDX_W = $clog2(DATA_MAX_W + 1);

    rx_state_e               state_q;
    logic [CNT_W-1:0]        phase_q;
    logic [IDX_W-1:0]        idx_q;
    logic [DATA_MAX_W-1:0]   shift_q;
    logic                    noisy_q;
    logic [IDX_W-1:0]        idx_last;

    assign idx_last = nine_bit ? IDX_W'(DATA_MAX_W - 1) : IDX_W'(DATA_MAX_W - 2);
    assign phase    = phase_q;
    assign wide     = (state_q == RX_START);
    assign bit_end  = tick && (state_q != RX_HUNT) && (phase_q == PH_LAST);

    always_comb begin
        char_out.valid = bit_end && (state_q == RX_STOP);
        char_out.noisy = noisy_q | bit_noisy;
        char_out.word  = nine_bit ? shift_q : {1'b0, shift_q[DATA_MAX_W-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_HUNT;
            phase_q <= '0;
            idx_q   <= '0;
            shift_q <= '0;
            noisy_q <= 1'b0;
        end else if (tick) begin
            if (state_q == RX_HUNT) begin
                if (!rxd) begin
                    state_q <= RX_START;
                    phase_q <= CNT_W'(1);
                    noisy_q <= 1'b0;
                end
            end else begin
                phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
                if (bit_end) begin
                    unique case (state_q)
                        RX_START: begin
                            if (bit_val) begin
                                state_q <= RX_HUNT;
                            end else begin
                                state_q <= RX_DATA;
                                idx_q   <= '0;
                                noisy_q <= bit_noisy;
                            end
                        end
                        RX_DATA: begin
                            shift_q <= {bit_val, shift_q[DATA_MAX_W-1:1]};
                            noisy_q <= noisy_q | bit_noisy;
                            idx_q   <= idx_q + 1'b1;
                            if (idx_q == idx_last)
                                state_q <= RX_STOP;
                        end
                        RX_STOP: state_q <= RX_HUNT;
                        default: state_q <= RX_HUNT;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/uart_ovs_hold.sv
module uart_ovs_hold
    import uart_ovs_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  rx_char_t              char_in,
    input  logic                  stat_rd,
    input  logic                  data_rd,
    output logic [DATA_MAX_W-1:0] rx_data,
    output logic                  rx_full,
    output logic                  rx_ovr,
    output logic                  rx_noise
);
    logic                  armed_q;
    logic                  full_q, ovr_q, noise_q;
    logic [DATA_MAX_W-1:0] data_q;
    logic                  clr;
    logic                  occupied;

    assign clr      = data_rd && armed_q;
    assign occupied = full_q && !clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            full_q  <= 1'b0;
            ovr_q   <= 1'b0;
            noise_q <= 1'b0;
            data_q  <= '0;
        end else begin
            if (data_rd)
                armed_q <= 1'b0;
            else if (stat_rd)
                armed_q <= full_q;

            if (char_in.valid) begin
                if (occupied) begin
                    ovr_q <= 1'b1;
                end else begin
                    full_q  <= 1'b1;
                    ovr_q   <= 1'b0;
                    noise_q <= char_in.noisy;
                    data_q  <= char_in.word;
                end
            end else if (clr) begin
                full_q  <= 1'b0;
                ovr_q   <= 1'b0;
                noise_q <= 1'b0;
            end
        end
    end

    assign rx_data  = data_q;
    assign rx_full  = full_q;
    assign rx_ovr   = ovr_q;
    assign rx_noise = noise_q;

endmodule

// File: rtl/uart_ovs_rx.sv
module uart_ovs_rx
    import uart_ovs_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rxd,
    input  logic       nine_bit,
    input  logic       stat_rd,
    input  logic       data_rd,
    output logic [8:0] rx_data,
    output logic       rx_full,
    output logic       rx_ovr,
    output logic       rx_noise
);
    localparam int CNT_W = $clog2(OVS);

    logic [CNT_W-1:0] phase;
    logic             wide;
    logic             bit_end;
    logic             bit_val;
    logic             bit_noisy;
    rx_char_t         char_c;

    uart_ovs_voter #(.OVS(OVS), .CNT_W(CNT_W)) voter_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .rxd      (rxd),
        .phase    (phase),
        .wide     (wide),
        .bit_end  (bit_end),
        .bit_val  (bit_val),
        .bit_noisy(bit_noisy)
    );

    uart_ovs_frame #(.OVS(OVS), .CNT_W(CNT_W)) frame_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .rxd      (rxd),
        .nine_bit (nine_bit),
        .bit_val  (bit_val),
        .bit_noisy(bit_noisy),
        .phase    (phase),
        .wide     (wide),
        .bit_end  (bit_end),
        .char_out (char_c)
    );

    uart_ovs_hold hold_i (
        .clk     (clk),
        .rst     (rst),
        .char_in (char_c),
        .stat_rd (stat_rd),
        .data_rd (data_rd),
        .rx_data (rx_data),
        .rx_full (rx_full),
        .rx_ovr  (rx_ovr),
        .rx_noise(rx_noise)
    );

endmodule

// File: rtl/uart_ovs_rx_chk.sv
module uart_ovs_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       data_rd,
    input logic [8:0] rx_data,
    input logic       rx_full,
    input logic       rx_ovr,
    input logic       rx_noise
);
    // R1: a character lands only on the edge after a sample tick.
    assert_full_after_tick_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_full) |-> $past(tick));

    // R2: the full flag drops only in response to a data read.
    assert_clear_needs_read_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_full) |-> $past(data_rd));

    // R4: held data is not overwritten while occupied and unread.
    assert_hold_stable_R4: assert property (@(posedge clk) disable iff (rst)
        (rx_full && !data_rd) |=> $stable(rx_data));

    // R4: overrun only arises over an occupied register.
    assert_ovr_needs_full_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ovr) |-> $past(rx_full));

    // R6: the noise flag describes the held character only.
    assert_noise_with_full_R6: assert property (@(posedge clk) disable iff (rst)
        rx_noise |-> rx_full);

    // R11: no character appears without a tick.
    assert_no_tick_no_char_R11: assert property (@(posedge clk) disable iff (rst)
        !tick |=> !$rose(rx_full));

    // R10: reset empties the register.
    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> (!rx_full && !rx_ovr && !rx_noise && rx_data == 9'd0));
endmodule

bind uart_ovs_rx uart_ovs_rx_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .data_rd (data_rd),
    .rx_data (rx_data),
    .rx_full (rx_full),
    .rx_ovr  (rx_ovr),
    .rx_noise(rx_noise)
);

// File: tb/uart_ovs_rx_tb_top.sv
module uart_ovs_rx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic       nine_bit = 1'b0;
    logic       stat_rd = 1'b0;
    logic       data_rd = 1'b0;
    logic [8:0] rx_data;
    logic       rx_full, rx_ovr, rx_noise;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_ovs_rx dut_i (
        .clk(clk), .rst(rst), .tick(tick), .rxd(rxd), .nine_bit(nine_bit),
        .stat_rd(stat_rd), .data_rd(data_rd), .rx_data(rx_data),
        .rx_full(rx_full), .rx_ovr(rx_ovr), .rx_noise(rx_noise)
    );

    // Behavioural reference model
    int  m_mode, m_ph, m_ones, m_taken, m_idx, m_word;
    bit  m_noisy;
    bit  e_full, e_ovr, e_noise, e_armed;
    int  e_data;

    always @(posedge clk) begin
        automatic bit push = 0;
        automatic bit pnoise = 0;
        automatic int pword = 0;
        if (rst) begin
            m_mode = 0; m_ph = 0; m_ones = 0; m_taken = 0; m_idx = 0; m_word = 0; m_noisy = 0;
            e_full = 0; e_ovr = 0; e_noise = 0; e_armed = 0; e_data = 0;
        end else begin
            if (tick) begin
                if (m_mode == 0) begin
                    if (rxd == 1'b0) begin m_mode = 1; m_ph = 1; m_noisy = 0; end
                end else begin
                    automatic bit v;
                    automatic bit inwin = (m_mode == 1) ? (m_ph >= 5 && m_ph <= 11)
                                                        : (m_ph >= 7 && m_ph <= 9);
                    if (inwin) begin m_ones += int'(rxd); m_taken++; end
                    if (m_ph == 15) begin
                        v = (2 * m_ones > m_taken);
                        if (m_ones != 0 && m_ones != m_taken) m_noisy = 1;
                        case (m_mode)
                            1: if (v) m_mode = 0; else begin m_mode = 2; m_idx = 0; m_word = 0; end
                            2: begin
                                if (v) m_word |= (1 << m_idx);
                                m_idx++;
                                if (m_idx == (nine_bit ? 9 : 8)) m_mode = 3;
                            end
                            default: begin push = 1; pnoise = m_noisy; pword = m_word; m_mode = 0; end
                        endcase
                        m_ones = 0; m_taken = 0; m_ph = 0;
                    end else m_ph++;
                end
            end
            begin
                automatic bit clr = data_rd && e_armed;
                if (data_rd) e_armed = 0; else if (stat_rd) e_armed = e_full;
                if (push) begin
                    if (e_full && !clr) e_ovr = 1;
                    else begin e_full = 1; e_ovr = 0; e_noise = pnoise; e_data = pword; end
                end else if (clr) begin
                    e_full = 0; e_ovr = 0; e_noise = 0;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (!done) begin
            check(rx_full  == e_full,  "R1 full vs model",  int'(rx_full),  int'(e_full));
            check(rx_ovr   == e_ovr,   "R4 ovr vs model",   int'(rx_ovr),   int'(e_ovr));
            check(rx_noise == e_noise, "R6 noise vs model", int'(rx_noise), int'(e_noise));
            check(int'(rx_data) == e_data, "R3 data vs model", int'(rx_data), e_data);
        end
    end

    task automatic one_tick(input bit v);
        @(negedge clk); rxd = v; tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic send_bit(input bit v, input int glitch);
        for (int p = 0; p < 16; p++) one_tick((p == glitch) ? !v : v);
    endtask

    // gbit: bit slot (0 = start) carrying a one-sample glitch at phase gph
    task automatic send_frame(input int word, input bit nine, input int gbit, input int gph);
        automatic int nb = nine ? 9 : 8;
        @(negedge clk); nine_bit = nine;
        send_bit(1'b0, (gbit == 0) ? gph : -1);
        for (int i = 0; i < nb; i++) send_bit(word[i], (gbit == i + 1) ? gph : -1);
        send_bit(1'b1, (gbit == nb + 1) ? gph : -1);
        one_tick(1'b1); one_tick(1'b1);
    endtask

    task automatic strobe_stat();
        @(negedge clk); stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic strobe_data();
        @(negedge clk); data_rd = 1'b1; @(negedge clk); data_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_all();
        strobe_stat(); strobe_data();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!rx_full && !rx_ovr && !rx_noise && rx_data == 0, "R10 reset state",
              {rx_ovr, rx_noise, rx_full}, 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check(!rx_full && rx_data == 0, "R10 after reset", int'(rx_full), 0);

        // R1 / R3: clean 8-bit frame
        send_frame(9'h0A5, 1'b0, -1, 0);
        check(rx_full == 1'b1, "R1 full after frame", int'(rx_full), 1);
        check(rx_data == 9'h0A5, "R3 8-bit data", int'(rx_data), 'h0A5);
        check(rx_noise == 1'b0, "R6 clean frame no noise", int'(rx_noise), 0);

        // R2: data read without a prior status read is ignored
        strobe_data();
        check(rx_full == 1'b1 && rx_data == 9'h0A5, "R2 lone data read ignored", int'(rx_full), 1);
        clear_all();
        check(rx_full == 1'b0, "R2 handshake clears full", int'(rx_full), 0);

        // R3: 9-bit frame with bit 8 set
        send_frame(9'h1C3, 1'b1, -1, 0);
        check(rx_data == 9'h1C3, "R3 9-bit data", int'(rx_data), 'h1C3);
        clear_all();

        // R3: 8-bit mode leaves bit 8 at 0 even after an all-ones byte
        send_frame(9'h0FF, 1'b0, -1, 0);
        check(rx_data == 9'h0FF, "R3 bit8 zero in 8-bit mode", int'(rx_data), 'h0FF);
        clear_all();

        // R7 / R6: glitch inside data bit 3 at the centre sample
        send_frame(9'h000, 1'b0, 4, 8);
        check(rx_data == 9'h000, "R7 majority keeps data", int'(rx_data), 0);
        check(rx_noise == 1'b1, "R6 noise from data bit", int'(rx_noise), 1);
        clear_all();
        check(rx_noise == 1'b0 && rx_full == 1'b0, "R5 noise cleared", int'(rx_noise), 0);

        // R6: noise in the stop bit
        send_frame(9'h03C, 1'b0, 9, 9);
        check(rx_noise == 1'b1 && rx_data == 9'h03C, "R6 noise from stop bit", int'(rx_noise), 1);
        clear_all();

        // R9: glitch outside the narrow window has no effect
        send_frame(9'h055, 1'b0, 3, 2);
        check(rx_noise == 1'b0 && rx_data == 9'h055, "R9 glitch outside window", int'(rx_noise), 0);
        clear_all();

        // R9: start-bit window reaches phase 5
        send_frame(9'h066, 1'b0, 0, 5);
        check(rx_noise == 1'b1 && rx_data == 9'h066, "R9 start window edge", int'(rx_noise), 1);
        clear_all();

        // R8: false start, low for 4 ticks only
        for (int p = 0; p < 4; p++) one_tick(1'b0);
        for (int p = 0; p < 40; p++) one_tick(1'b1);
        check(rx_full == 1'b0, "R8 false start no char", int'(rx_full), 0);
        send_frame(9'h081, 1'b0, -1, 0);
        check(rx_full == 1'b1 && rx_data == 9'h081, "R8 recovers after false start", int'(rx_data), 'h081);

        // R4: second frame (noisy) arrives while first is unread
        send_frame(9'h022, 1'b0, 2, 8);
        check(rx_ovr == 1'b1, "R4 overrun set", int'(rx_ovr), 1);
        check(rx_data == 9'h081 && rx_noise == 1'b0, "R4 old char kept", int'(rx_data), 'h081);
        clear_all();
        check(rx_ovr == 1'b0 && rx_full == 1'b0, "R5 overrun cleared", int'(rx_ovr), 0);

        // R11: line activity without ticks does nothing
        @(negedge clk); rxd = 1'b0;
        repeat (600) @(negedge clk);
        rxd = 1'b1;
        for (int p = 0; p < 20; p++) one_tick(1'b1);
        check(rx_full == 1'b0, "R11 no tick no char", int'(rx_full), 0);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule